// File: doc/BRIEF.md
# Multi-Wavefront Typed Issue Arbiter

This block decides which wavefronts issue instructions in a compute unit made of several SIMD groups. Each SIMD has its own pool of wavefront slots. Every slot shows whether its next instruction is ready and which category that instruction belongs to. One issue unit serves all SIMDs. It gives the SIMDs their turns one after another in a fixed rotation, and on a SIMD's turn it can issue several instructions in the same cycle. Each of those instructions is of a different category and comes from a different wavefront.

Within a category, the arbiter prefers the wavefront that has waited longest. Categories are filled in a fixed priority order up to a per-turn cap. Instructions of the special class never use an issue slot. The owning slot retires them right away, whether or not its SIMD has the turn. Dependency checking is done upstream, and its result reaches this block only as the ready flag.

Top module: `wave_issue_arbiter`

## Requirements
- R1: After synchronous active-low reset is released, the turn output reads 0. It then advances by one on every clock and wraps from NUM_SIMD-1 back to 0.
- R2: An acknowledge is raised only for slots that belong to the SIMD holding the turn. Slot k of SIMD s is flat index s*SLOTS+k.
- R3: The category codes are 0 vector ALU, 1 scalar ALU, 2 branch, 3 vector memory, 4 local data share, 5 global data share/export, 6 special, and 7 reserved. The issue strobe for category c goes high only for a ready slot showing code c. Codes 6 and 7 never issue.
- R4: For each category, the chosen slot is the one with the largest age. A slot's age counts the consecutive clock edges at which it was ready with a code 0 to 5 and was not acknowledged. The age saturates at 2^AGE_W-1 and drops to 0 in every other case.
- R5: When the largest age is shared by several slots, the slot with the lowest index wins.
- R6: Each issue goes to a distinct wavefront. The number of acknowledges equals the number of issue strobes, and each acknowledged slot is the one named on the strobe for its category.
- R7: At most MAX_ISSUE (default 5) instructions issue per turn. Categories are granted in ascending code order, so when all six have candidates, code 5 is held back.
- R8: A ready slot showing code 6 gets a consume strobe in the same cycle, on any SIMD and whether or not that SIMD has the turn. It never gets an acknowledge.
- R9: A category with no ready candidate keeps its strobe low, and its wavefront field reads 0.
- R10: While reset is held low, no acknowledge, issue or consume strobe is raised. Reset clears all ages and returns the turn to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| slotReady | input | NUM_SIMD*SLOTS | Per-slot flag: the head instruction is ready |
| slotCat | input | NUM_SIMD*SLOTS*3 | Per-slot category code of the head instruction |
| issueSimd | output | SIMD_W | SIMD that holds the turn this cycle |
| issueValid | output | 6 | Per-category issue strobe |
| issueWave | output | 6*WAVE_W | Per-category chosen slot index within the turn SIMD |
| slotAck | output | NUM_SIMD*SLOTS | Acknowledge to each issued slot |
| slotConsume | output | NUM_SIMD*SLOTS | Retire strobe for special-class heads |

## Verification
The bench first holds reset while slots are busy, which shows that nothing leaks out during reset. It then runs directed patterns. When every slot offers vector ALU work, the pattern separates correct turn gating and lowest-index tie breaking from wrong ones. When all six categories are offered on every SIMD, the pattern exposes an error in the issue cap or in the priority order. Special-only and reserved-only patterns tell consume apart from issue, and a single-category pattern checks that idle strobes stay quiet. A long random sweep follows, with ready flags and codes changing every cycle, so ages build up unevenly. The bench keeps an arithmetic model of the ages, so it can tell oldest-first selection apart from index order.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int CAT_W      = 3;
  localparam int NUM_CAT    = 6;
  localparam int TURN_MAX_W = 4;

  typedef enum logic [CAT_W-1:0] {
    CAT_VALU    = 3'd0,
    CAT_SALU    = 3'd1,
    CAT_BRANCH  = 3'd2,
    CAT_VMEM    = 3'd3,
    CAT_LDS     = 3'd4,
    CAT_EXPORT  = 3'd5,
    CAT_SPECIAL = 3'd6,
    CAT_RSVD    = 3'd7
  } instCat_e;

  typedef struct packed {
    logic [TURN_MAX_W-1:0] turn;
    logic                  issueEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/issue_turn_ctrl.sv
module issue_turn_ctrl
  import issue_pkg::*;
#(
  parameter int NUM_SIMD = 4
) (
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t ctrl
);
  localparam logic [TURN_MAX_W-1:0] LAST = TURN_MAX_W'(NUM_SIMD - 1);

  logic [TURN_MAX_W-1:0] turnQ;

  always_ff @(posedge clk) begin
    if (!rstN)               turnQ <= '0;
    else if (turnQ == LAST)  turnQ <= '0;
    else                     turnQ <= turnQ + 1'b1;
  end

  always_comb begin
    ctrl.turn    = turnQ;
    ctrl.issueEn = rstN;
  end

  // R1: turn stays within the SIMD count and steps by one modulo it
  p_turn_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    int'(turnQ) < NUM_SIMD);
  p_turn_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> int'(turnQ) == (int'($past(turnQ)) + 1) % NUM_SIMD);
endmodule

// File: rtl/issue_select_dp.sv
module issue_select_dp
  import issue_pkg::*;
#(
  parameter int NUM_SIMD  = 4,
  parameter int SLOTS     = 10,
  parameter int AGE_W     = 6,
  parameter int MAX_ISSUE = 5,
  localparam int TOTAL    = NUM_SIMD * SLOTS,
  localparam int WAVE_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              ctrl,
  input  logic [TOTAL-1:0]          slotReady,
  input  logic [TOTAL*CAT_W-1:0]    slotCat,
  output logic [NUM_CAT-1:0]        issueValid,
  output logic [NUM_CAT*WAVE_W-1:0] issueWave,
  output logic [TOTAL-1:0]          slotAck,
  output logic [TOTAL-1:0]          slotConsume
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [TOTAL-1:0][AGE_W-1:0] age;

  // oldest-first pick per category, categories granted in code order
  always_comb begin
    int issued;
    issueValid = '0;
    issueWave  = '0;
    slotAck    = '0;
    issued     = 0;
    for (int c = 0; c < NUM_CAT; c++) begin
      logic             found;
      int               bestSlot;
      logic [AGE_W-1:0] bestAge;
      found    = 1'b0;
      bestSlot = 0;
      bestAge  = '0;
      for (int s = 0; s < SLOTS; s++) begin
        int idx;
        idx = int'(ctrl.turn) * SLOTS + s;
        if (idx < TOTAL && ctrl.issueEn && slotReady[idx] &&
            slotCat[idx*CAT_W +: CAT_W] == CAT_W'(c) &&
            (!found || age[idx] > bestAge)) begin
          found    = 1'b1;
          bestSlot = s;
          bestAge  = age[idx];
        end
      end
      if (found && issued < MAX_ISSUE) begin
        issueValid[c]                 = 1'b1;
        issueWave[c*WAVE_W +: WAVE_W] = WAVE_W'(bestSlot);
        slotAck[int'(ctrl.turn) * SLOTS + bestSlot] = 1'b1;
        issued++;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < TOTAL; g++) begin : gSlot
      logic [CAT_W-1:0] code;
      logic             issuable;
      assign code           = slotCat[g*CAT_W +: CAT_W];
      assign issuable       = code < CAT_W'(NUM_CAT);
      assign slotConsume[g] = rstN && slotReady[g] && code == CAT_SPECIAL;

      always_ff @(posedge clk) begin
        if (!rstN)                                       age[g] <= '0;
        else if (!slotReady[g] || !issuable || slotAck[g]) age[g] <= '0;
        else if (age[g] != AGE_MAX)                      age[g] <= age[g] + 1'b1;
      end
    end
  endgenerate

  // R6: one acknowledge per issue strobe
  p_ack_matches_issue_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(slotAck) == $countones(issueValid));
  // R7: per-turn issue cap
  p_issue_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(issueValid) <= MAX_ISSUE);
  // R8: a consumed slot is never acknowledged
  p_consume_no_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slotConsume & slotAck) == '0);
  // R3: only ready slots are acknowledged
  p_ack_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (slotAck & ~slotReady) == '0);
  // R4: an acknowledged slot restarts its age
  p_age_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    slotAck[0] |=> age[0] == '0);
endmodule

// File: rtl/wave_issue_arbiter.sv
module wave_issue_arbiter
  import issue_pkg::*;
#(
  parameter int NUM_SIMD  = 4,
  parameter int SLOTS     = 10,
  parameter int AGE_W     = 6,
  parameter int MAX_ISSUE = 5,
  localparam int TOTAL    = NUM_SIMD * SLOTS,
  localparam int SIMD_W   = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int WAVE_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [TOTAL-1:0]          slotReady,
  input  logic [TOTAL*CAT_W-1:0]    slotCat,
  output logic [SIMD_W-1:0]         issueSimd,
  output logic [NUM_CAT-1:0]        issueValid,
  output logic [NUM_CAT*WAVE_W-1:0] issueWave,
  output logic [TOTAL-1:0]          slotAck,
  output logic [TOTAL-1:0]          slotConsume
);
  ctrlStrobes_t ctrl;

  issue_turn_ctrl #(.NUM_SIMD(NUM_SIMD)) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl)
  );

  issue_select_dp #(
    .NUM_SIMD(NUM_SIMD), .SLOTS(SLOTS), .AGE_W(AGE_W), .MAX_ISSUE(MAX_ISSUE)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .slotReady   (slotReady),
    .slotCat     (slotCat),
    .issueValid  (issueValid),
    .issueWave   (issueWave),
    .slotAck     (slotAck),
    .slotConsume (slotConsume)
  );

  assign issueSimd = ctrl.turn[SIMD_W-1:0];

  // R10: nothing leaves the block while reset is held
  p_quiet_in_reset_r10: assert property (@(posedge clk)
    !rstN |-> (slotAck == '0 && issueValid == '0 && slotConsume == '0));
endmodule

// File: tb/test_wave_issue_arbiter.sv
module test_wave_issue_arbiter;
  localparam int NS = 4, SL = 10, AW = 6, MI = 5;
  localparam int TOT = NS * SL, NC = 6, WW = 4, SW = 2;
  localparam int AMAX = (1 << AW) - 1;

  logic clk = 0, rstN = 0;
  logic [TOT-1:0]    slotReady = '0;
  logic [TOT*3-1:0]  slotCat = '0;
  logic [SW-1:0]     issueSimd;
  logic [NC-1:0]     issueValid;
  logic [NC*WW-1:0]  issueWave;
  logic [TOT-1:0]    slotAck, slotConsume;

  int compared = 0, mismatched = 0;
  int mAge [TOT];
  int mTurn = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wave_issue_arbiter i_wave_issue_arbiter (
    .clk(clk), .rstN(rstN), .slotReady(slotReady), .slotCat(slotCat),
    .issueSimd(issueSimd), .issueValid(issueValid), .issueWave(issueWave),
    .slotAck(slotAck), .slotConsume(slotConsume));

  task automatic check(string tag, string field, logic [63:0] got, logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s got %h exp %h", tag, field, got, exp);
    end
  endtask

  // one cycle: inputs already set after the previous edge
  task automatic step(string tag);
    logic [NC-1:0]    eValid;
    logic [NC*WW-1:0] eWave;
    logic [TOT-1:0]   eAck, eCons;
    int n;
    #2;
    eValid = '0; eWave = '0; eAck = '0; eCons = '0; n = 0;
    if (rstN) begin
      for (int i = 0; i < TOT; i++)
        if (slotReady[i] && slotCat[i*3 +: 3] == 3'd6) eCons[i] = 1'b1;
      for (int c = 0; c < NC; c++) begin
        int best;
        best = -1;
        for (int s = 0; s < SL; s++) begin
          int i;
          i = mTurn * SL + s;
          if (slotReady[i] && int'(slotCat[i*3 +: 3]) == c &&
              (best < 0 || mAge[i] > mAge[mTurn*SL + best])) best = s;
        end
        if (best >= 0 && n < MI) begin
          eValid[c] = 1'b1;
          eWave[c*WW +: WW] = WW'(best);
          eAck[mTurn*SL + best] = 1'b1;
          n++;
        end
      end
    end
    check(tag, "turn R1",     64'(issueSimd),   64'(mTurn));
    check(tag, "valid R3",    64'(issueValid),  64'(eValid));
    check(tag, "wave R4",     64'(issueWave),   64'(eWave));
    check(tag, "ack R6",      64'(slotAck),     64'(eAck));
    check(tag, "consume R8",  64'(slotConsume), 64'(eCons));
    @(posedge clk);
    for (int i = 0; i < TOT; i++) begin
      if (!rstN) mAge[i] = 0;
      else if (slotReady[i] && slotCat[i*3 +: 3] < 3'd6 && !eAck[i])
        mAge[i] = (mAge[i] < AMAX) ? mAge[i] + 1 : AMAX;
      else mAge[i] = 0;
    end
    mTurn = rstN ? (mTurn + 1) % NS : 0;
    #1;
  endtask

  task automatic fillAll(logic rdy, logic [2:0] code);
    for (int i = 0; i < TOT; i++) begin
      slotReady[i] = rdy;
      slotCat[i*3 +: 3] = code;
    end
  endtask

  initial begin
    for (int i = 0; i < TOT; i++) mAge[i] = 0;
    // R10: busy inputs during reset
    fillAll(1'b1, 3'd6);
    @(posedge clk); #1;
    for (int k = 0; k < 4; k++) step("R10");
    rstN = 1;
    // R1: idle rotation
    fillAll(1'b0, 3'd0);
    for (int k = 0; k < 9; k++) step("R1");
    // R2/R5: every slot offers vector ALU with equal ages
    fillAll(1'b1, 3'd0);
    for (int k = 0; k < 12; k++) step("R2_R5");
    fillAll(1'b0, 3'd0);
    step("R9");
    // R7: six categories on slots 0..5 of every SIMD
    for (int i = 0; i < TOT; i++) begin
      slotReady[i] = (i % SL) < 6;
      slotCat[i*3 +: 3] = 3'((i % SL) % 6);
    end
    for (int k = 0; k < 8; k++) step("R7");
    // R8: special everywhere
    fillAll(1'b1, 3'd6);
    for (int k = 0; k < 6; k++) step("R8");
    // R3: reserved code never issues
    fillAll(1'b1, 3'd7);
    for (int k = 0; k < 6; k++) step("R3");
    // R9: only branch work on odd slots
    fillAll(1'b0, 3'd2);
    for (int i = 1; i < TOT; i += 2) slotReady[i] = 1'b1;
    for (int k = 0; k < 10; k++) step("R9");
    // R4: random sweep, ages grow unevenly
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < TOT; i++) begin
        slotReady[i] = ($urandom % 4) != 0;
        if (($urandom % 3) == 0) slotCat[i*3 +: 3] = 3'($urandom % 8);
      end
      step("R4");
    end
    // R10: reset again clears turn and ages
    rstN = 0;
    step("R10");
    rstN = 1;
    fillAll(1'b1, 3'd1);
    for (int k = 0; k < 6; k++) step("R10");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R1 got hang exp finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule